// File: doc/BRIEF.md
# External Data-Memory Bus Sequencer

This block turns a single core-side request into one read or write cycle on a multiplexed external memory bus. It places the high address byte on a dedicated output port for the whole access. It places the low address byte on a shared 8-bit port while the address latch enable is high. It then turns that shared port into the data path. The read or write strobe, both active low, is pulsed for a programmable width. One machine cycle is four clocks. The access lasts two machine cycles at the shortest setting.

A 3-bit stretch setting, written through a small configuration input, adds four clocks per step to the strobe and so to the whole access. Slow memories and memory-mapped peripherals can then be reached without extra glue logic. After reset the setting is 1, so the first accesses are not full speed. The stretch value is latched when a request is accepted, so a change made mid-access affects only later accesses. The program-store enable output stays inactive, because this block only performs data accesses.

The sequencer is built around a state machine with these states. ST_IDLE waits for a request. ST_ADDR holds the latch enable high with the low address on the port. ST_HOLD keeps the low address on the port for one clock after the latch enable falls. ST_SETUP releases the port for a read, or drives write data for a write. ST_STROBE holds one strobe low. ST_RECOVER keeps write data on the port for one clock after the strobe rises. ST_FINISH pulses done. The transitions run in order:
- ST_IDLE to ST_ADDR when a request is seen.
- ST_ADDR to ST_HOLD when its 2-clock count runs out.
- ST_HOLD to ST_SETUP to ST_STROBE, one clock each.
- ST_STROBE to ST_RECOVER when the strobe count runs out.
- ST_RECOVER to ST_FINISH, then back to ST_IDLE.

Top module: `xbus_seq`

## Requirements
- R1: After reset, ale is 0, rd_n, wr_n and psen_n are 1, ad_oe and done are 0, and the stretch setting is 1, so the first access lasts 12 clocks.
- R2: With stretch s latched, an access lasts (s+2)*4 clocks. This is counted from the first clock with ale high through the clock with done high, both included.
- R3: ale is high for exactly the first 2 clocks of an access. While ale is high, and for 1 clock after it falls, ad_oe is 1 and ad_out carries req_addr[7:0]. During the strobe, addr_hi carries req_addr[15:8].
- R4: In a read, rd_n is low for 2+4*s consecutive clocks and ad_oe is 0 throughout. rdata takes the ad_in value present on the last clock with rd_n low.
- R5: In a write, wr_n is low for 2+4*s consecutive clocks. ad_oe is 1 and ad_out carries req_wdata from 1 clock before wr_n falls until 1 clock after it rises.
- R6: rd_n and wr_n are never low together, and neither is low while ale is high.
- R7: psen_n stays 1 during every access.
- R8: done is high for exactly one clock at the end of each access. In that clock, rdata holds the read result.
- R9: A request raised while an access is in progress is ignored. It starts no new cycle and does not change the one under way.
- R10: A pulse on cfg_we loads cfg_stretch (0 to 7) into the stretch setting. It applies to requests accepted after the write. An access already running keeps the stretch it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (four clocks per machine cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the stretch setting |
| cfg_stretch | input | 3 | New stretch value |
| req | input | 1 | Access request, taken only when idle |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Last read result |
| done | output | 1 | One-clock end-of-access pulse |
| ad_out | output | 8 | Multiplexed address/data port, outgoing value |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| ad_in | input | 8 | Multiplexed port, incoming value |
| addr_hi | output | 8 | High address byte port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| psen_n | output | 1 | Program-store enable, held inactive |

## Verification
The bench builds the block with its default parameters: 8-bit data, 16-bit address, a 3-bit stretch field, four clocks per machine cycle and a reset stretch of 1. These values make every stretch from 0 to 7 reachable. That covers the shortest 8-clock access, the 36-clock access with a 30-clock strobe, and the reset-default length before any configuration write. With the same widths, the bench also sends a stray request during an access and changes the stretch while an access is running.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/xbus_stretch_reg.sv
module xbus_stretch_reg #(
    parameter int SW      = 3,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= SW'(RST_VAL);
        else if (we)
            q <= din;
    end
endmodule

// File: rtl/xbus_cnt.sv
module xbus_cnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (dec && q != '0)
            q <= q - 1'b1;
    end

    assign zero = (q == '0);

    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (q != '0)); // R2
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 16,
    parameter int SW          = 3,
    parameter int MC_CLK      = 4,
    parameter int STRETCH_RST = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rdata,
    output logic          done,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic [AW-DW-1:0] addr_hi,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          psen_n
);
    localparam int ALE_CLK = MC_CLK / 2;
    localparam int SMAX    = (1 << SW) - 1;
    localparam int STB_MAX = ALE_CLK + MC_CLK * SMAX;
    localparam int CW      = $clog2(STB_MAX + 1);

    seq_state_e    state_q, state_d;
    logic [SW-1:0] cur_stretch;
    logic [SW-1:0] lat_s;
    logic          lat_we;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [CW-1:0] stb_len;
    logic          cnt_load, cnt_dec, cnt_zero;
    logic [CW-1:0] cnt_val;
    logic          accept;

    xbus_stretch_reg #(.SW(SW), .RST_VAL(STRETCH_RST)) u_stretch (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .din(cfg_stretch), .q(cur_stretch)
    );

    assign stb_len  = CW'(ALE_CLK) + CW'(MC_CLK) * CW'(lat_s);
    assign accept   = (state_q == ST_IDLE) && req;
    assign cnt_load = accept || (state_q == ST_HOLD);
    assign cnt_val  = accept ? CW'(ALE_CLK - 1) : (stb_len - 1'b1);
    assign cnt_dec  = ((state_q == ST_ADDR) || (state_q == ST_STROBE)) && !cnt_zero;

    xbus_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .zero(cnt_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req) state_d = ST_ADDR;
            ST_ADDR:    if (cnt_zero) state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_STROBE;
            ST_STROBE:  if (cnt_zero) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lat_s     <= '0;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lat_s     <= cur_stretch;
                lat_we    <= req_we;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if (state_q == ST_STROBE && cnt_zero && !lat_we)
                rdata <= ad_in;
        end
    end

    // bus outputs
    always_comb begin
        ale    = (state_q == ST_ADDR);
        ad_oe  = (state_q == ST_ADDR) || (state_q == ST_HOLD) ||
                 (lat_we && ((state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                             (state_q == ST_RECOVER)));
        ad_out = ((state_q == ST_ADDR) || (state_q == ST_HOLD)) ? lat_addr[DW-1:0] : lat_wdata;
        rd_n   = !((state_q == ST_STROBE) && !lat_we);
        wr_n   = !((state_q == ST_STROBE) && lat_we);
        psen_n = 1'b1;
        done   = (state_q == ST_FINISH);
        addr_hi = lat_addr[AW-1:DW];
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(state_q) == ST_IDLE); // R1
    AST_ALE_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_out))); // R3
    AST_RD_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R4
    AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out))); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R6
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R6
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(lat_addr)); // R9
    AST_STRETCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(lat_s)); // R10
endmodule

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [2:0]  s;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0; logic [2:0] cfg_stretch = 0;
    logic req = 0, req_we = 0; logic [15:0] req_addr = 0; logic [7:0] req_wdata = 0;
    logic [7:0] rdata, ad_out, ad_in, addr_hi;
    logic done, ad_oe, ale, rd_n, wr_n, psen_n;

    int n_chk = 0, n_bad = 0;
    exp_t q[$];
    int cur_s = 1;
    int last_len = 0;
    int ale_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rdata(rdata), .done(done), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model on the bus
    logic [7:0] lo_lat = 0;
    assign ad_in = (!rd_n) ? mem_val({addr_hi, lo_lat}) : 8'h00;

    // monitor
    logic prev_ale = 0, prev_wr = 1, prev_oe = 0, want_done_low = 0;
    logic [7:0] prev_out = 0, wdat = 0;
    int tcnt = 0, rd_low = 0, wr_low = 0;
    logic bad_port = 0, bad_psen = 0, bad_ovl = 0, ok_ahold = 0, ok_setup = 0, ok_hold = 0, bad_aoe = 0;
    logic [7:0] hi_cap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done_low) begin
                chk(done == 1'b0, "R8 done width", done, 0);
                want_done_low = 0;
            end
            if (ale && !prev_ale) begin
                ale_rises++;
                chk(q.size() != 0, "R9 unexpected access", 1, 0);
                tcnt = 0; rd_low = 0; wr_low = 0;
                bad_port = 0; bad_psen = 0; bad_ovl = 0; bad_aoe = 0;
                ok_ahold = 0; ok_setup = 0; ok_hold = 0;
            end
            tcnt++;
            if (ale) begin
                lo_lat = ad_out;
                if (!ad_oe) bad_aoe = 1;
            end
            if (prev_ale && !ale) ok_ahold = ad_oe && (ad_out == lo_lat);
            if (!rd_n) begin
                rd_low++;
                hi_cap = addr_hi;
                if (ad_oe) bad_port = 1;
            end
            if (!wr_n) begin
                wr_low++;
                hi_cap = addr_hi;
                if (prev_wr) ok_setup = prev_oe && (prev_out == ad_out);
            end
            if (!prev_wr && wr_n) begin
                wdat = ad_out;
                ok_hold = ad_oe && (ad_out == prev_out);
            end
            if (!psen_n) bad_psen = 1;
            if ((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n))) bad_ovl = 1;
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 done without request", 1, 0);
                end else begin
                    exp_t e;
                    int stb;
                    e = q.pop_front();
                    stb = 2 + 4 * int'(e.s);
                    last_len = tcnt;
                    chk(tcnt == (int'(e.s) + 2) * 4, "R2 access length", tcnt, (int'(e.s) + 2) * 4);
                    chk({hi_cap, lo_lat} == e.addr && !bad_aoe, "R3 address", {hi_cap, lo_lat}, e.addr);
                    chk(ok_ahold, "R3 low address hold", ok_ahold, 1);
                    chk(!bad_ovl, "R6 strobe overlap", bad_ovl, 0);
                    chk(!bad_psen, "R7 psen_n", bad_psen, 0);
                    if (!e.we) begin
                        chk(rd_low == stb && wr_low == 0, "R4 read strobe width", rd_low, stb);
                        chk(!bad_port, "R4 port released", bad_port, 0);
                        chk(rdata == mem_val(e.addr), "R8 read data at done", rdata, mem_val(e.addr));
                    end else begin
                        chk(wr_low == stb && rd_low == 0, "R5 write strobe width", wr_low, stb);
                        chk(wdat == e.data, "R5 write data", wdat, e.data);
                        chk(ok_setup && ok_hold, "R5 data setup/hold", {ok_setup, ok_hold}, 3);
                    end
                end
                want_done_low = 1;
            end
        end
        prev_ale = ale; prev_wr = wr_n; prev_oe = ad_oe; prev_out = ad_out;
    end

    task automatic set_stretch(input int s);
        @(negedge clk); cfg_we = 1; cfg_stretch = 3'(s);
        @(negedge clk); cfg_we = 0; cur_s = s;
    endtask

    // kind: 0 plain, 1 stray request mid-access, 2 stretch change to 0 mid-access
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d, input int kind);
        exp_t e;
        @(negedge clk);
        req = 1; req_we = we; req_addr = a; req_wdata = d;
        e.we = we; e.addr = a; e.data = d; e.s = 3'(cur_s);
        q.push_back(e);
        @(negedge clk);
        req = 0;
        if (kind == 1) begin
            @(negedge clk); @(negedge clk);
            req = 1; req_we = ~we; req_addr = 16'h7777; req_wdata = 8'h99;
            @(negedge clk);
            req = 0;
        end else if (kind == 2) begin
            @(negedge clk); cfg_we = 1; cfg_stretch = 3'd0;
            @(negedge clk); cfg_we = 0; cur_s = 0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int rises;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ale == 0 && done == 0 && ad_oe == 0, "R1 reset outputs low", {ale, done, ad_oe}, 0);
        chk(rd_n && wr_n && psen_n, "R1 reset strobes high", {rd_n, wr_n, psen_n}, 7);

        access(1'b0, 16'h1234, 8'h00, 0);
        chk(last_len == 12, "R1 default stretch length", last_len, 12);
        access(1'b1, 16'hABCD, 8'h3C, 0);

        for (int s = 0; s < 8; s++) begin
            set_stretch(s);
            access(1'b0, 16'(16'h2000 + s * 16'h0111), 8'h00, 0);
            access(1'b1, 16'(16'h8000 + s * 16'h0321), 8'(8'h50 + s), 0);
        end

        // R9: stray request while busy
        set_stretch(2);
        rises = ale_rises;
        access(1'b0, 16'h4242, 8'h00, 1);
        repeat (15) @(negedge clk);
        chk(ale_rises == rises + 1, "R9 stray request ignored", ale_rises - rises, 1);
        chk(q.size() == 0, "R9 scoreboard drained", q.size(), 0);

        // R10: stretch change during an access
        set_stretch(3);
        access(1'b1, 16'h5A5A, 8'hC3, 2);
        chk(last_len == 20, "R10 in-flight keeps stretch", last_len, 20);
        access(1'b0, 16'h0F0F, 8'h00, 0);
        chk(last_len == 8, "R10 new stretch applied", last_len, 8);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule